// File: doc/BRIEF.md
# Change-of-State Digital Input Controller

This block samples 48 digital input lines, organised as six groups of eight, and presents them to a host through an 8-byte register window with an 8-bit data path. Every line is an input only. Each line passes through a synchroniser before it is used. The host reads the synchronised levels one group per byte.

The block compares each group's synchronised value with its value in the previous cycle. A rising or falling transition on any bit of a group counts as a change in that group. If the host has enabled that group, the change is latched, and the interrupt request output is held high while any latched group bit is set.

Offset 7 is shared. A write to offset 7 sets the per-group enables. A read of offset 7 returns the latched groups and an active-low pending flag, and the same read clears the latch. Per-bit masking is left to host software.

Top module: `cos_input_ctrl`

## Requirements
- R1: A read at offset 0, 1, 2, 4, 5 or 6 returns group 0, 1, 2, 3, 4 or 5 respectively. Bit n of the returned byte is synchronised input (group*8 + n).
- R2: A read at offset 3 returns 0x00.
- R3: A write to offset 7 loads data bits 0-5 as the enables for groups 0-5. Reset clears every enable.
- R4: A rising or falling edge on any input of an enabled group sets that group's bit (bit g = group g) in the offset-7 status byte. The bit stays set until offset 7 is read. irqOut is high no later than the third rising clock edge after the input changes.
- R5: A change in a group whose enable is clear is not latched and does not raise irqOut.
- R6: In the offset-7 status byte, bit 6 is 0 when a group bit is latched and 1 when none is. Bit 7 is always 0.
- R7: irqOut is high exactly while at least one group bit is latched.
- R8: A read of offset 7 returns the status as it stood before the read, then clears all latched bits. A change detected in the same cycle as that read stays latched for the next read.
- R9: A write to any offset other than 7 has no effect.
- R10: After reset, irqOut is low and no group bit is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 48 | Asynchronous digital inputs |
| busAddr | input | 3 | Byte offset within the window |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data, registered, valid the cycle after busRd |
| irqOut | output | 1 | Level interrupt request, active high |

## Verification
The hardest case to reach from the ports is a change that reaches the detector in the same cycle as a status read. The clear and the new set then collide on one clock edge. The stimulus changes one input on a falling edge and issues the offset-7 read exactly two cycles later, when the second synchroniser stage first exposes the change. It then checks three things: the read returns the old, empty status; irqOut stays high; and a second read returns the new group bit.

// File: rtl/cos_pkg.sv
`timescale 1ns/1ps
package cos_pkg;
  localparam int NUM_GROUPS   = 6;
  localparam int GROUP_W      = 8;
  localparam int NUM_PINS     = NUM_GROUPS * GROUP_W;
  localparam int ADDR_W       = 3;
  localparam int DATA_W       = 8;
  localparam int IRQ_FLAG_BIT = 6;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;
  localparam logic [ADDR_W-1:0] HOLE_ADDR   = 3'd3;

  typedef struct packed {
    logic       rdAny;
    logic       rdStatus;
    logic       wrEnable;
    logic       grpValid;
    logic [2:0] grpSel;
  } ctlStrobes_t;
endpackage

// File: rtl/cos_ctrl.sv
`timescale 1ns/1ps
module cos_ctrl
  import cos_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output ctlStrobes_t       strobes
);
  always_comb begin
    strobes          = '0;
    strobes.rdAny    = busRd;
    strobes.rdStatus = busRd && (busAddr == STATUS_ADDR);
    strobes.wrEnable = busWr && (busAddr == STATUS_ADDR);
    if (busAddr < HOLE_ADDR) begin
      strobes.grpValid = 1'b1;
      strobes.grpSel   = busAddr;
    end else if ((busAddr > HOLE_ADDR) && (busAddr < STATUS_ADDR)) begin
      strobes.grpValid = 1'b1;
      strobes.grpSel   = busAddr - 3'd1;
    end
  end
endmodule

// File: rtl/cos_datapath.sv
`timescale 1ns/1ps
module cos_datapath
  import cos_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctlStrobes_t         strobes,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0]   pinNow, pinPrev;
  logic [NUM_GROUPS-1:0] groupChg, enable, latch;
  logic [GROUP_W-1:0]    pinBytes [NUM_GROUPS];
  logic [DATA_W-1:0]     rdNext;

  assign pinNow = syncQ[SYNC_STAGES-1];
  assign irqOut = |latch;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign pinBytes[g] = pinNow[g*GROUP_W +: GROUP_W];
    assign groupChg[g] = |(pinNow[g*GROUP_W +: GROUP_W] ^ pinPrev[g*GROUP_W +: GROUP_W]);
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdStatus) begin
      rdNext[NUM_GROUPS-1:0] = latch;
      rdNext[IRQ_FLAG_BIT]   = ~(|latch);
    end else if (strobes.grpValid) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (strobes.grpSel == 3'(g)) rdNext = pinBytes[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= '0;
      enable  <= '0;
      latch   <= '0;
      rdData  <= '0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinIn};
      pinPrev <= pinNow;
      if (strobes.wrEnable) enable <= wrData[NUM_GROUPS-1:0];
      latch <= (strobes.rdStatus ? '0 : latch) | (groupChg & enable);
      if (strobes.rdAny) rdData <= rdNext;
    end
  end

  assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEnable |=> enable == $past(wrData[NUM_GROUPS-1:0]));
  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEnable |=> $stable(enable));
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStatus |=> (latch & $past(latch)) == $past(latch));
  assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latch & ~$past(latch)) & ~$past(enable)) == '0);
  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> (latch & ~$past(groupChg & enable)) == '0);
  assert_status_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> (rdData[IRQ_FLAG_BIT] == ~$past(irqOut)) && !rdData[7]);
  assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdAny && !strobes.rdStatus && !strobes.grpValid) |=> rdData == '0);
endmodule

// File: rtl/cos_input_ctrl.sv
`timescale 1ns/1ps
module cos_input_ctrl
  import cos_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  output logic                irqOut
);
  ctlStrobes_t strobes;

  cos_ctrl uCtrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes)
  );

  cos_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobes (strobes),
    .wrData  (busWData),
    .rdData  (busRData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/sim_cos_input_ctrl.sv
`timescale 1ns/1ps
module sim_cos_input_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] pinIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWData = '0;
  logic [7:0]  busRData;
  logic        irqOut;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  cos_input_ctrl u0 (.clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWData(busWData), .busRData(busRData), .irqOut(irqOut));

  // {enables[5:0], pins[47:0]}
  localparam logic [53:0] VEC [0:7] = '{
    {6'h3F, 48'h0000_0000_0001},
    {6'h3F, 48'h8000_0000_0001},
    {6'h3F, 48'h8000_0000_0000},
    {6'h15, 48'h8000_00FF_FF00},
    {6'h0A, 48'h1234_5678_9ABC},
    {6'h00, 48'hFFFF_FFFF_FFFF},
    {6'h3F, 48'h0000_0000_0000},
    {6'h20, 48'h0100_0000_0000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; d = busRData;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [5:0] chgGroups(input logic [47:0] a, input logic [47:0] b);
    logic [5:0] m;
    for (int g = 0; g < 6; g++) m[g] = |((a ^ b) >> (g*8) & 48'hFF);
    return m;
  endfunction

  function automatic logic [2:0] offOf(input int g);
    return (g < 3) ? 3'(g) : 3'(g + 1);
  endfunction

  initial begin
    logic [7:0]  d;
    logic [47:0] oldP;
    logic [5:0]  exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 irq after reset", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d); check("R10 R6 status after reset", d, 8'h40);
    busRead(3'd3, d); check("R2 hole offset", d, 8'h00);
    // R3: enables cleared by reset, so changes are ignored
    pinIn = 48'h0000_0000_00FF; settle();
    check("R3 no irq with reset enables", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d); check("R3 status with reset enables", d, 8'h40);
    pinIn = '0; settle();
    oldP = '0;

    // table walk: R1 R4 R5 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      busWrite(3'd7, {2'b00, VEC[v][53:48]});
      pinIn = VEC[v][47:0];
      settle();
      exp = chgGroups(oldP, VEC[v][47:0]) & VEC[v][53:48];
      check("R7 irq level", {7'd0, irqOut}, {7'd0, |exp});
      busRead(3'd7, d);
      check("R4 R5 R6 status", d, {1'b0, ~(|exp), exp});
      check("R8 irq cleared by read", {7'd0, irqOut}, 8'h00);
      for (int g = 0; g < 6; g++) begin
        busRead(offOf(g), d);
        check("R1 input byte", d, VEC[v][g*8 +: 8]);
      end
      oldP = VEC[v][47:0];
    end
    busRead(3'd3, d); check("R2 hole with inputs set", d, 8'h00);

    // R8: a change detected in the same cycle as the status read survives it
    busWrite(3'd7, 8'h3F);
    @(negedge clk); pinIn = oldP ^ 48'h0000_0400_0000; // group 3 bit 2
    @(negedge clk);
    @(negedge clk); busAddr = 3'd7; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; d = busRData;
    check("R8 same-cycle read returns old status", d, 8'h40);
    check("R8 irq kept after same-cycle read", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d); check("R8 kept change on next read", d, 8'h08);
    busRead(3'd7, d); check("R8 cleared after read", d, 8'h40);
    oldP = pinIn;

    // R9: writes elsewhere ignored
    busWrite(3'd7, 8'h01);
    busWrite(3'd0, 8'h3F);
    busWrite(3'd3, 8'hFF);
    busWrite(3'd5, 8'h3E);
    pinIn = oldP ^ 48'h0000_0100_0000; settle();
    check("R9 enables untouched by other writes", {7'd0, irqOut}, 8'h00);
    busRead(3'd0, d); check("R9 input byte unchanged by write", d, pinIn[7:0]);
    pinIn = pinIn ^ 48'h0000_0000_0080; settle();
    check("R4 falling/rising on enabled group 0", {7'd0, irqOut}, 8'h01);

    // R10: mid-run reset clears latch and enables
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R10 irq low after reset", {7'd0, irqOut}, 8'h00);
    pinIn = ~pinIn; settle();
    check("R3 enables cleared by reset", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d); check("R10 status after reset", d, 8'h40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule